// File: doc/BRIEF.md
# SPI Slave Serial Shift Engine

This block is the slave side of a full-duplex SPI link. An external master drives the serial clock and the active-low select. The engine shifts one byte in from MOSI and one byte out on MISO, most significant bit first. Both clock polarities and both clock phases are supported. The serial clock, select and MOSI pins are asynchronous to the system clock. Each passes through a two-stage synchroniser, and the clock and select edges are found in the system clock domain.

Software, or a neighbouring block, writes the next outgoing byte into a holding register with a one-cycle load strobe. The shift register copies the holding register when a byte starts. If no new byte has been loaded, the previous one is sent again.

Each completed incoming byte appears on `rx_data` together with a one-cycle `rx_valid` pulse. When select rises, MISO is released and any partly shifted byte is discarded. Mode-fault detection, master clock generation and interrupts belong to other blocks.

Top module: `spi_slv_engine`

## Requirements
- R1: After a synchronous reset, `rx_valid` and `busy` are 0, `miso` is 0, and `miso_oe` is 0 while `ss_n` is high.
- R2: Every completed byte of 8 sampled bits produces exactly one single-cycle `rx_valid` pulse. `rx_data` then holds the MOSI bits, with the first sampled bit in bit 7.
- R3: MISO carries the byte most recently loaded with `tx_load` (bit 7 first). A byte that is not reloaded is sent again on the next transfer.
- R4: `miso_oe` is 1 exactly while the synchronised select is low. It follows the `ss_n` pin two system clocks later.
- R5: While the synchronised select is high, serial clock edges and MOSI have no effect. No bit is counted and no byte completes.
- R6: A rise of select in the middle of a byte aborts it. No `rx_valid` pulse is given, `busy` falls, and the next byte starts again from bit 7.
- R7: With `cpha`=0, bit 7 appears on MISO as soon as the falling edge of select is detected. MOSI is sampled on leading clock edges and MISO moves on trailing edges. Once 8 bits are done, further clock edges are ignored until select rises again.
- R8: With `cpha`=1, the first leading edge of each byte loads the shift register, and later leading edges advance MISO. MOSI is sampled on trailing edges. Select may stay low across back-to-back bytes.
- R9: `cpol` gives the idle level of the serial clock. A leading edge leaves the idle level and a trailing edge returns to it.
- R10: `busy` is 1 from the first sampled bit of a byte until that byte completes or aborts.
- R11: The clock, select and MOSI pins each pass through two synchronising flip-flops. A pin edge acts on the shift logic at the third system clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| ss_n | input | 1 | Active-low slave select (asynchronous) |
| mosi | input | 1 | Serial data from the master (asynchronous) |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 samples on trailing edges |
| tx_data | input | DATA_W | Byte to send on the next transfer |
| tx_load | input | 1 | One-cycle strobe that captures `tx_data` |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| rx_data | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` updates |
| busy | output | 1 | A byte is partly shifted |

## Verification
The hardest states to reach from the pins are a select rise that lands between two sampled bits, and clock edges that arrive while select is high. Both must leave no trace in the next byte. The bench reaches them with a transfer task that can stop after any number of bits. It then raises select, toggles the serial clock and MOSI while deselected, and runs a full byte afterwards.

A behavioural model counts the three-cycle synchroniser delay on every pin. This lets the MISO timing, the output enable and the `busy` window be compared on every system clock, not only at byte boundaries.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // serial pin bundle as seen by the synchroniser
  typedef struct packed {
    logic ss;
    logic sclk;
    logic mosi;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{ss: 1'b1, sclk: 1'b0, mosi: 1'b0};
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int                WIDTH   = 3,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge (
  input  logic clk,
  input  logic rst,
  input  logic cpol,
  input  logic sclk_s,
  input  logic ss_s,
  output logic lead,
  output logic trail,
  output logic ss_fall
);
  logic sclk_q, ss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_s;
    end
  end

  // leading edge leaves the idle level, trailing edge returns to it
  assign lead    = (sclk_q == cpol) && (sclk_s != cpol);
  assign trail   = (sclk_q != cpol) && (sclk_s == cpol);
  assign ss_fall = ss_q && !ss_s;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead, trail})); // R9
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpha,
  input  logic              lead,
  input  logic              trail,
  input  logic              ss_s,
  input  logic              ss_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_buf,
  output logic              miso,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy
);
  localparam int               CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic [CNT_W-1:0]  cnt;
  logic              done;
  logic              sample_ev, shift_ev, load_ev;

  always_comb begin
    sample_ev = 1'b0;
    shift_ev  = 1'b0;
    load_ev   = 1'b0;
    if (!ss_s) begin
      if (!cpha) begin
        load_ev   = ss_fall;
        sample_ev = !ss_fall && !done && lead;
        shift_ev  = !ss_fall && !done && trail;
      end else begin
        sample_ev = trail;
        load_ev   = lead && (cnt == '0);
        shift_ev  = lead && (cnt != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr    <= '0;
      rx_sr    <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (ss_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end
      if (load_ev) begin
        tx_sr <= tx_buf;
        cnt   <= '0;
        done  <= 1'b0;
      end else if (shift_ev) begin
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
      if (sample_ev) begin
        rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
        if (cnt == LAST) begin
          rx_data  <= {rx_sr[DATA_W-2:0], mosi_s};
          rx_valid <= 1'b1;
          cnt      <= '0;
          done     <= !cpha;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign miso = tx_sr[DATA_W-1];
  assign busy = (cnt != '0);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R2
  AST_VALID_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(cnt) == LAST && !$past(ss_s))); // R2
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ss_s |=> (cnt == '0 && !rx_valid)); // R6
  AST_DESELECT_FREEZES_RX: assert property (@(posedge clk) disable iff (rst)
    ss_s |=> $stable(rx_sr)); // R5
  AST_FIRST_BIT_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
    (ss_fall && !ss_s && !cpha) |=> (miso == $past(tx_buf[DATA_W-1]))); // R7
  AST_MISO_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!lead && !trail && !ss_fall) |=> $stable(miso)); // R8
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              miso,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy
);
  import spi_slv_pkg::*;

  spi_pins_t         pins_raw, pins_s;
  logic [DATA_W-1:0] tx_buf;
  logic              lead, trail, ss_fall;

  assign pins_raw = '{ss: ss_n, sclk: sclk, mosi: mosi};

  spi_slv_sync #(
    .WIDTH  ($bits(spi_pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  spi_slv_edge u_edge (
    .clk(clk), .rst(rst), .cpol(cpol),
    .sclk_s(pins_s.sclk), .ss_s(pins_s.ss),
    .lead(lead), .trail(trail), .ss_fall(ss_fall)
  );

  always_ff @(posedge clk) begin
    if (rst)          tx_buf <= '0;
    else if (tx_load) tx_buf <= tx_data;
  end

  spi_slv_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .cpha(cpha),
    .lead(lead), .trail(trail), .ss_s(pins_s.ss), .ss_fall(ss_fall),
    .mosi_s(pins_s.mosi), .tx_buf(tx_buf),
    .miso(miso), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy)
  );

  assign miso_oe = !pins_s.ss;

  AST_OE_TRACKS_PIN: assert property (@(posedge clk) disable iff (rst)
    ($past(ss_n, 2) && $past(!rst, 2)) |-> !miso_oe); // R4
endmodule

// File: tb/tb_spi_slv_engine.sv
`timescale 1ns/1ps
module tb_spi_slv_engine;
  localparam int HP = 6; // serial half period in system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_load = 1'b0;
  logic miso, miso_oe, rx_valid, busy;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  spi_slv_engine dut (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .cpol(cpol), .cpha(cpha), .tx_data(tx_data), .tx_load(tx_load),
    .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy)
  );

  int n_cmp = 0, n_bad = 0;
  int vcount = 0;
  logic [7:0] last_rx = 8'h00;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // pin history: index 0 is the newest sample, bits are {ss, sclk, mosi}
  logic [2:0] hist [3] = '{3'b100, 3'b100, 3'b100};
  logic [7:0] m_tx = 0, m_rx = 0, m_buf = 0, m_rdata = 0;
  int   m_cnt = 0;
  bit   m_done = 0, m_valid = 0, m_oe = 0;

  always @(posedge clk) begin
    logic s_ss, q_ss, s_ck, q_ck, s_mo, ld, tr;
    if (rst) begin
      m_tx = 0; m_rx = 0; m_buf = 0; m_rdata = 0;
      m_cnt = 0; m_done = 0; m_valid = 0;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = 3'b100;
    end else begin
      s_ss = hist[1][2]; q_ss = hist[2][2];
      s_ck = hist[1][1]; q_ck = hist[2][1];
      s_mo = hist[1][0];
      ld = (q_ck == cpol) && (s_ck != cpol);
      tr = (q_ck != cpol) && (s_ck == cpol);
      m_valid = 0;
      if (s_ss) begin
        m_cnt = 0; m_done = 0;
      end else if (!cpha) begin
        if (q_ss) begin
          m_tx = m_buf; m_cnt = 0; m_done = 0;
        end else if (!m_done && ld) begin
          m_rx = {m_rx[6:0], s_mo};
          if (m_cnt == 7) begin m_rdata = m_rx; m_valid = 1; m_cnt = 0; m_done = 1; end
          else m_cnt++;
        end else if (!m_done && tr) begin
          m_tx = m_tx << 1;
        end
      end else begin
        if (ld) begin
          if (m_cnt == 0) m_tx = m_buf; else m_tx = m_tx << 1;
        end else if (tr) begin
          m_rx = {m_rx[6:0], s_mo};
          if (m_cnt == 7) begin m_rdata = m_rx; m_valid = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end
      if (tx_load) m_buf = tx_data;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = {ss_n, sclk, mosi};
    end
    m_oe = !hist[1][2];
    cmp_en = 1'b1;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3", "miso", 32'(miso), 32'(m_tx[7]));
      chk("R4/R11", "miso_oe", 32'(miso_oe), 32'(m_oe));
      chk("R2", "rx_valid", 32'(rx_valid), 32'(m_valid));
      chk("R2", "rx_data", 32'(rx_data), 32'(m_rdata));
      chk("R10", "busy", 32'(busy), 32'(m_cnt != 0));
      if (rx_valid) begin vcount++; last_rx = rx_data; end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic ph);
    @(negedge clk); cpol = pol; cpha = ph; sclk = pol;
    tick(6);
  endtask

  task automatic xfer(input logic [7:0] mb, input int nbits, output logic [7:0] got);
    got = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        @(negedge clk); mosi = mb[i];
        tick(HP);
        sclk = ~cpol; got[i] = miso;
        tick(HP);
        sclk = cpol;
      end else begin
        @(negedge clk); sclk = ~cpol; mosi = mb[i];
        tick(HP);
        sclk = cpol; got[i] = miso;
        tick(HP);
      end
    end
    tick(HP);
  endtask

  task automatic select(input logic v);
    @(negedge clk); ss_n = v;
    tick(8);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] got;
    int v0;
    tick(5);
    rst = 1'b0;
    tick(4);
    chk("R1", "reset rx_valid", 32'(rx_valid), 0);
    chk("R1", "reset busy", 32'(busy), 0);
    chk("R1", "reset miso_oe", 32'(miso_oe), 0);
    chk("R1", "reset miso", 32'(miso), 0);

    // cpol 0, cpha 0
    set_mode(1'b0, 1'b0);
    load_tx(8'hA5);
    select(1'b0);
    chk("R7", "first bit after select", 32'(miso), 1);
    chk("R4", "oe when selected", 32'(miso_oe), 1);
    xfer(8'h3C, 8, got);
    chk("R3", "master got", 32'(got), 32'hA5);
    chk("R2", "rx byte", 32'(last_rx), 32'h3C);
    v0 = vcount;
    xfer(8'hFF, 2, got); // extra edges after a complete byte
    chk("R7", "edges after byte ignored", 32'(vcount), 32'(v0));
    chk("R7", "busy after byte", 32'(busy), 0);
    select(1'b1);
    chk("R4", "oe released", 32'(miso_oe), 0);

    // cpol 1, cpha 0
    set_mode(1'b1, 1'b0);
    load_tx(8'h96);
    select(1'b0);
    xfer(8'hC3, 8, got);
    chk("R9", "cpol1 master got", 32'(got), 32'h96);
    chk("R9", "cpol1 rx byte", 32'(last_rx), 32'hC3);
    select(1'b1);

    // cpha 1, back to back with select held low
    set_mode(1'b0, 1'b1);
    load_tx(8'h5A);
    v0 = vcount;
    select(1'b0);
    xfer(8'h81, 8, got);
    chk("R8", "byte1 master got", 32'(got), 32'h5A);
    chk("R8", "byte1 rx", 32'(last_rx), 32'h81);
    load_tx(8'hF0);
    xfer(8'h7E, 8, got);
    chk("R8", "byte2 master got", 32'(got), 32'hF0);
    chk("R8", "byte2 rx", 32'(last_rx), 32'h7E);
    chk("R8", "two valid pulses", 32'(vcount - v0), 2);
    select(1'b1);

    // cpha 1, cpol 1, no reload: previous byte is resent
    set_mode(1'b1, 1'b1);
    select(1'b0);
    xfer(8'h24, 8, got);
    chk("R3", "resend without reload", 32'(got), 32'hF0);
    chk("R9", "cpol1 cpha1 rx", 32'(last_rx), 32'h24);
    select(1'b1);

    // abort in mid-byte
    set_mode(1'b0, 1'b0);
    load_tx(8'hC9);
    v0 = vcount;
    select(1'b0);
    xfer(8'hE7, 3, got);
    chk("R10", "busy mid-byte", 32'(busy), 1);
    select(1'b1);
    chk("R6", "busy after abort", 32'(busy), 0);
    chk("R6", "no pulse on abort", 32'(vcount), 32'(v0));
    chk("R4", "oe after abort", 32'(miso_oe), 0);
    select(1'b0);
    xfer(8'h1D, 8, got);
    chk("R6", "clean byte after abort", 32'(last_rx), 32'h1D);
    chk("R6", "full tx after abort", 32'(got), 32'hC9);
    select(1'b1);

    // clock edges while deselected
    v0 = vcount;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); sclk = ~sclk; mosi = k[0];
      tick(HP);
    end
    @(negedge clk); sclk = cpol;
    tick(8);
    chk("R5", "no pulse while deselected", 32'(vcount), 32'(v0));
    chk("R5", "busy while deselected", 32'(busy), 0);
    select(1'b0);
    xfer(8'h6B, 8, got);
    chk("R5", "byte after ignored edges", 32'(last_rx), 32'h6B);
    select(1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule